// File: doc/BRIEF.md
# Wide-Immediate Instruction Decoder

This block sits between an instruction fetch stage and an execution stage. It takes one 64-bit instruction word per accepted transfer and breaks it into its fields: opcode, instruction class, source-select bit, destination and source register numbers, a signed 16-bit offset and a 64-bit immediate. For single-word instructions, the immediate is the sign-extended 32-bit field.

The wide-constant load uses opcode 0x18 and spans two consecutive words. The first word is held inside the block and produces no output. The second word must be a filler word whose low 32 bits are all zero. Once it arrives, one decoded instruction leaves the block. Its 64-bit constant has the filler word's immediate in the top half and the first word's immediate, zero-extended, in the bottom half.

Bad encodings are not dropped. They leave the block with an illegal flag set. Both sides of the block use valid/ready handshakes, and a single output register sits between them.

Top module: `wide_imm_decoder`

## Requirements
- R1: Field positions in a word, from bit 0 upward, are:
  - opcode in bits [7:0];
  - destination register in bits [11:8];
  - source register in bits [15:12];
  - signed offset in bits [31:16];
  - signed immediate in bits [63:32].

  For a single-word instruction, the 64-bit immediate output is the 32-bit immediate sign-extended.
- R2: The class output equals opcode bits [2:0]. The source-select output equals opcode bit 3, where 1 means the operand comes from a register and 0 means it comes from the immediate.
- R3: A destination or source register number above 10 in a single-word instruction sets the illegal flag on that word's output.
- R4: An accepted first word with opcode 0x18, register numbers of 10 or less and a zero offset produces no output. The block then waits for a second word.
- R5: After a valid filler word, the block emits one output with the wide flag set and illegal clear. Its constant is {filler imm, first-word imm}, with the lower half taken without sign extension.
- R6: A filler word with any non-zero bit in [31:0] is still consumed. It produces one output with both the wide and illegal flags set. The next word is then decoded as a fresh instruction.
- R7: A word with opcode 0x18 and either a non-zero offset or a register number above 10 is emitted at once, with the wide and illegal flags set. The block does not wait for a second word.
- R8: While the output is valid and not taken, the output fields stay stable and in_ready_o is low.
- R9: After reset, out_valid_o is low and in_ready_o is high.
- R10: If no filler word arrives, the block stays in the waiting state for as long as needed and emits nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_valid_i | input | 1 | Fetch word valid |
| in_ready_o | output | 1 | Block can accept a word |
| in_word_i | input | 64 | Instruction word |
| out_valid_o | output | 1 | Decoded instruction valid |
| out_ready_i | input | 1 | Consumer takes the decoded instruction |
| out_opcode_o | output | 8 | Full opcode |
| out_class_o | output | 3 | Instruction class |
| out_src_sel_o | output | 1 | 1 = register operand, 0 = immediate operand |
| out_dst_o | output | 4 | Destination register number |
| out_src_o | output | 4 | Source register number |
| out_offset_o | output | 16 | Signed offset |
| out_imm_o | output | 64 | Sign-extended immediate or assembled 64-bit constant |
| out_wide_o | output | 1 | Instruction used the wide-load opcode |
| out_illegal_o | output | 1 | Encoding was malformed |

## Verification
The assertions check, on every cycle:
- output stability under backpressure;
- that a legal output never carries a register number above 10;
- that a legal wide output has opcode 0x18;
- that accepting a good first word never produces an output on the next cycle.

Only the bench's scenarios can show the rest:
- that the 64-bit constant is assembled correctly, with a zero-extended lower half;
- that the block returns to normal decoding after a bad filler word;
- that it waits indefinitely when the stream pauses between the two words.

// File: rtl/wi_pkg.sv
package wi_pkg;
  localparam int unsigned WORD_W   = 64;
  localparam int unsigned OPC_W    = 8;
  localparam int unsigned REG_W    = 4;
  localparam int unsigned OFF_W    = 16;
  localparam int unsigned IMM_W    = 32;
  localparam int unsigned CLS_W    = 3;
  localparam int unsigned REG_MAX  = 10;
  localparam logic [OPC_W-1:0] WIDE_OPC = 8'h18;

  typedef struct packed {
    logic [OPC_W-1:0] opcode;
    logic [REG_W-1:0] dst;
    logic [REG_W-1:0] src;
    logic [OFF_W-1:0] offset;
    logic [IMM_W-1:0] imm;
  } fields_t;

  typedef struct packed {
    logic [OPC_W-1:0]  opcode;
    logic [CLS_W-1:0]  cls;
    logic              src_sel;
    logic [REG_W-1:0]  dst;
    logic [REG_W-1:0]  src;
    logic [OFF_W-1:0]  offset;
    logic [WORD_W-1:0] imm;
    logic              wide;
    logic              illegal;
  } decoded_t;

  typedef enum logic {ST_IDLE, ST_WAIT_HI} state_e;
endpackage

// File: rtl/wi_field_split.sv
module wi_field_split
  import wi_pkg::*;
(
  input  logic [WORD_W-1:0] word_i,
  output fields_t           fields_o,
  output logic              regs_ok_o,
  output logic              wide_opc_o,
  output logic              filler_ok_o
);
  localparam int unsigned DST_LO = OPC_W;
  localparam int unsigned SRC_LO = DST_LO + REG_W;
  localparam int unsigned OFF_LO = SRC_LO + REG_W;
  localparam int unsigned IMM_LO = OFF_LO + OFF_W;

  always_comb begin
    fields_o.opcode = word_i[DST_LO-1:0];
    fields_o.dst    = word_i[SRC_LO-1:DST_LO];
    fields_o.src    = word_i[OFF_LO-1:SRC_LO];
    fields_o.offset = word_i[IMM_LO-1:OFF_LO];
    fields_o.imm    = word_i[WORD_W-1:IMM_LO];
  end

  assign regs_ok_o   = (32'(fields_o.dst) <= REG_MAX) && (32'(fields_o.src) <= REG_MAX);
  assign wide_opc_o  = (fields_o.opcode == WIDE_OPC);
  // filler word: everything below the immediate must be zero
  assign filler_ok_o = (word_i[IMM_LO-1:0] == '0);
endmodule

// File: rtl/wi_out_hold.sv
module wi_out_hold
  import wi_pkg::*;
(
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     load_i,
  input  decoded_t data_i,
  input  logic     ready_i,
  output logic     valid_o,
  output logic     free_o,
  output decoded_t data_o
);
  assign free_o = !valid_o || ready_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      data_o  <= '0;
    end else if (free_o) begin
      valid_o <= load_i;
      if (load_i) data_o <= data_i;
    end
  end

  a_r8_hold_stable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o && !ready_i |=> valid_o && $stable(data_o));
endmodule

// File: rtl/wide_imm_decoder.sv
module wide_imm_decoder
  import wi_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              in_valid_i,
  output logic              in_ready_o,
  input  logic [WORD_W-1:0] in_word_i,
  output logic              out_valid_o,
  input  logic              out_ready_i,
  output logic [OPC_W-1:0]  out_opcode_o,
  output logic [CLS_W-1:0]  out_class_o,
  output logic              out_src_sel_o,
  output logic [REG_W-1:0]  out_dst_o,
  output logic [REG_W-1:0]  out_src_o,
  output logic [OFF_W-1:0]  out_offset_o,
  output logic [WORD_W-1:0] out_imm_o,
  output logic              out_wide_o,
  output logic              out_illegal_o
);
  fields_t  cur_f, first_q;
  logic     regs_ok, wide_opc, filler_ok;
  state_e   state_q, state_d;
  logic     fire, emit, keep_first;
  decoded_t dec_d, dec_q;

  wi_field_split i_split (
    .word_i      (in_word_i),
    .fields_o    (cur_f),
    .regs_ok_o   (regs_ok),
    .wide_opc_o  (wide_opc),
    .filler_ok_o (filler_ok)
  );

  assign fire = in_valid_i && in_ready_o;

  always_comb begin
    state_d    = state_q;
    emit       = 1'b0;
    keep_first = 1'b0;
    dec_d      = '0;
    if (fire) begin
      if (state_q == ST_WAIT_HI) begin
        emit           = 1'b1;
        dec_d.opcode   = first_q.opcode;
        dec_d.cls      = first_q.opcode[CLS_W-1:0];
        dec_d.src_sel  = first_q.opcode[CLS_W];
        dec_d.dst      = first_q.dst;
        dec_d.src      = first_q.src;
        dec_d.offset   = first_q.offset;
        dec_d.imm      = {cur_f.imm, first_q.imm};  // low half zero-extended
        dec_d.wide     = 1'b1;
        dec_d.illegal  = !filler_ok;
        state_d        = ST_IDLE;
      end else if (wide_opc && regs_ok && (cur_f.offset == '0)) begin
        keep_first = 1'b1;
        state_d    = ST_WAIT_HI;
      end else begin
        emit           = 1'b1;
        dec_d.opcode   = cur_f.opcode;
        dec_d.cls      = cur_f.opcode[CLS_W-1:0];
        dec_d.src_sel  = cur_f.opcode[CLS_W];
        dec_d.dst      = cur_f.dst;
        dec_d.src      = cur_f.src;
        dec_d.offset   = cur_f.offset;
        dec_d.imm      = {{(WORD_W-IMM_W){cur_f.imm[IMM_W-1]}}, cur_f.imm};
        dec_d.wide     = wide_opc;
        dec_d.illegal  = !regs_ok || wide_opc;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      first_q <= '0;
    end else begin
      state_q <= state_d;
      if (keep_first) first_q <= cur_f;
    end
  end

  wi_out_hold i_hold (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .load_i  (emit),
    .data_i  (dec_d),
    .ready_i (out_ready_i),
    .valid_o (out_valid_o),
    .free_o  (in_ready_o),
    .data_o  (dec_q)
  );

  assign out_opcode_o  = dec_q.opcode;
  assign out_class_o   = dec_q.cls;
  assign out_src_sel_o = dec_q.src_sel;
  assign out_dst_o     = dec_q.dst;
  assign out_src_o     = dec_q.src;
  assign out_offset_o  = dec_q.offset;
  assign out_imm_o     = dec_q.imm;
  assign out_wide_o    = dec_q.wide;
  assign out_illegal_o = dec_q.illegal;

  a_r3_legal_regs_in_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o && !out_illegal_o |-> (32'(out_dst_o) <= REG_MAX) && (32'(out_src_o) <= REG_MAX));
  a_r5_wide_has_wide_opc: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o && out_wide_o && !out_illegal_o |-> out_opcode_o == WIDE_OPC);
  a_r4_first_word_silent: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fire && state_q == ST_IDLE && wide_opc && regs_ok && cur_f.offset == '0
      |=> !out_valid_o && state_q == ST_WAIT_HI);
  a_r8_no_accept_when_stalled: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o && !out_ready_i |-> !in_ready_o);
endmodule

// File: tb/test_wide_imm_decoder.sv
module test_wide_imm_decoder;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [63:0] in_word = '0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [7:0]  out_opcode;
  logic [2:0]  out_class;
  logic        out_src_sel;
  logic [3:0]  out_dst, out_src;
  logic [15:0] out_offset;
  logic [63:0] out_imm;
  logic        out_wide, out_illegal;
  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  wide_imm_decoder i_wide_imm_decoder (
    .clk_i(clk), .rst_ni(rst_n),
    .in_valid_i(in_valid), .in_ready_o(in_ready), .in_word_i(in_word),
    .out_valid_o(out_valid), .out_ready_i(out_ready),
    .out_opcode_o(out_opcode), .out_class_o(out_class), .out_src_sel_o(out_src_sel),
    .out_dst_o(out_dst), .out_src_o(out_src), .out_offset_o(out_offset),
    .out_imm_o(out_imm), .out_wide_o(out_wide), .out_illegal_o(out_illegal)
  );

  function automatic logic [63:0] mk(logic [31:0] imm, logic [15:0] off,
                                     logic [3:0] src, logic [3:0] dst, logic [7:0] op);
    return {imm, off, src, dst, op};
  endfunction

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // returns at the negedge following the accepting edge
  task automatic send(logic [63:0] w);
    @(negedge clk);
    in_valid = 1'b1;
    in_word  = w;
    while (!in_ready) @(negedge clk);
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic expect_single(string req, logic [63:0] w, logic ill);
    logic [63:0] ext = {{32{w[63]}}, w[63:32]};
    check({req, " valid"}, 64'(out_valid), 64'd1);
    check({req, " opcode"}, 64'(out_opcode), 64'(w[7:0]));
    check({req, " class"}, 64'(out_class), 64'(w[2:0]));
    check({req, " src_sel"}, 64'(out_src_sel), 64'(w[3]));
    check({req, " dst"}, 64'(out_dst), 64'(w[11:8]));
    check({req, " src"}, 64'(out_src), 64'(w[15:12]));
    check({req, " offset"}, 64'(out_offset), 64'(w[31:16]));
    check({req, " imm"}, out_imm, ext);
    check({req, " illegal"}, 64'(out_illegal), 64'(ill));
  endtask

  task automatic t_reset();
    check("R9 out_valid", 64'(out_valid), 64'd0);
    check("R9 in_ready", 64'(in_ready), 64'd1);
  endtask

  task automatic t_basic();
    logic [63:0] w;
    w = mk(32'hFFFF_FF80, 16'hFFFC, 4'd10, 4'd3, 8'hBF);
    send(w); expect_single("R1 R2 neg", w, 1'b0);
    w = mk(32'h1234_5678, 16'h7FFF, 4'd0, 4'd0, 8'h07);
    send(w); expect_single("R1 R2 pos", w, 1'b0);
    check("R2 wide clear", 64'(out_wide), 64'd0);
  endtask

  task automatic t_bad_reg();
    logic [63:0] w;
    w = mk(32'h5, 16'h0, 4'd1, 4'd11, 8'h04);
    send(w); expect_single("R3 dst11", w, 1'b1);
    w = mk(32'h5, 16'h0, 4'd15, 4'd2, 8'h0C);
    send(w); expect_single("R3 src15", w, 1'b1);
  endtask

  task automatic t_wide();
    send(mk(32'h89AB_CDEF, 16'h0, 4'd0, 4'd2, 8'h18));
    check("R4 no output", 64'(out_valid), 64'd0);
    send(mk(32'h0123_4567, 16'h0, 4'd0, 4'd0, 8'h00));
    check("R5 valid", 64'(out_valid), 64'd1);
    check("R5 const", out_imm, 64'h0123_4567_89AB_CDEF);
    check("R5 wide", 64'(out_wide), 64'd1);
    check("R5 legal", 64'(out_illegal), 64'd0);
    check("R5 dst", 64'(out_dst), 64'd2);
  endtask

  task automatic t_bad_filler();
    logic [63:0] w;
    send(mk(32'h1, 16'h0, 4'd0, 4'd1, 8'h18));
    send(mk(32'h2, 16'h0, 4'd0, 4'd1, 8'h00));
    check("R6 valid", 64'(out_valid), 64'd1);
    check("R6 illegal", 64'(out_illegal), 64'd1);
    check("R6 wide", 64'(out_wide), 64'd1);
    w = mk(32'h42, 16'h3, 4'd4, 4'd5, 8'h0F);
    send(w); expect_single("R6 resumes", w, 1'b0);
  endtask

  task automatic t_bad_first();
    send(mk(32'h7, 16'h1, 4'd0, 4'd1, 8'h18));
    check("R7 immediate out", 64'(out_valid), 64'd1);
    check("R7 illegal", 64'(out_illegal), 64'd1);
    check("R7 wide", 64'(out_wide), 64'd1);
    send(mk(32'h7, 16'h0, 4'd0, 4'd12, 8'h18));
    check("R7 reg out", 64'(out_valid), 64'd1);
    check("R7 reg illegal", 64'(out_illegal), 64'd1);
  endtask

  task automatic t_pause();
    send(mk(32'hCAFE_0000, 16'h0, 4'd0, 4'd9, 8'h18));
    for (int i = 0; i < 10; i++) begin
      check("R10 silent", 64'(out_valid), 64'd0);
      @(negedge clk);
    end
    send(mk(32'hFFFF_FFFF, 16'h0, 4'd0, 4'd0, 8'h00));
    check("R10 const", out_imm, 64'hFFFF_FFFF_CAFE_0000);
    check("R10 legal", 64'(out_illegal), 64'd0);
  endtask

  task automatic t_backpressure();
    logic [63:0] a, b;
    a = mk(32'h11, 16'h1, 4'd1, 4'd1, 8'h0C);
    b = mk(32'h22, 16'h2, 4'd2, 4'd2, 8'h04);
    @(negedge clk); out_ready = 1'b0;
    send(a);
    @(negedge clk); in_valid = 1'b1; in_word = b;
    for (int i = 0; i < 3; i++) begin
      check("R8 in_ready low", 64'(in_ready), 64'd0);
      check("R8 imm held", out_imm, 64'h11);
      @(negedge clk);
    end
    out_ready = 1'b1;
    @(negedge clk); in_valid = 1'b0;
    expect_single("R8 next", b, 1'b0);
  endtask

  initial begin
    fork
      begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_basic();
        t_bad_reg();
        t_wide();
        t_bad_filler();
        t_bad_first();
        t_pause();
        t_backpressure();
      end
      begin
        repeat (5000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    disable fork;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule